// File: doc/BRIEF.md
# Prioritized interrupt level dispatcher

This block decides, once per request, whether a pending interrupt at a given priority level may be taken by the processor. When it qualifies, the block computes the redirected program counter and the new processor status word. It records the interrupted program counter and status in save registers that it owns. All of this lands on one clock edge.

Levels 2 and above are high-priority. Each has its own vector and its own pair of save registers, one for the program counter and one for the status word. Level 1 has no vector of its own. It is turned into a general exception: a user exception, a kernel exception, or a double exception if the processor is already in exception mode. A level-1 interrupt also writes a fixed cause code.

Vector addresses may be relocated: each fixed address is rebased from a default table base onto a base value supplied at the input.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is asserted, and after it is released until the first taken request, taken_o, new_pc_o, new_status_o, exc_kind_o, cause_o, every save register and depc_o are all zero.
- R2: A request is taken only when all of these hold. req_valid_i is high. The level is greater than the current interrupt level, status_i[3:0]. The level is at most NLEVEL. The bitwise AND of that level's mask (level_mask_i[(L-1)*NINT +: NINT]), int_set_i and int_en_i is nonzero. Otherwise no output other than taken_o changes.
- R3: taken_o is high for exactly the one cycle after the clock edge that accepted a qualifying request, and low after every other edge.
- R4: For a taken level L of 2 or more, save-PC slot L (save_pc_o[(L-1)*XLEN +: XLEN]) receives pc_i. Save-status slot L (save_st_o[(L-2)*ST_W +: ST_W]) receives status_i. No other save slot changes.
- R5: For a taken level L of 2 or more, new_status_o equals status_i with bits [3:0] replaced by L and bit 4 (exception mode) set; all other bits are kept.
- R6: For a taken level L of 2 or more, the fixed vector is DEF_VECBASE + LVL_OFS + (L-2)*LVL_STRIDE.
- R7: Every taken level-1 request writes cause_o with L1_CAUSE (4). High levels leave cause_o unchanged.
- R8: A taken level-1 request with status_i bit 4 set yields exc_kind_o = 3 (double) and the DBL_OFS vector. pc_i goes to depc_o when HAS_DEPC is 1, otherwise to save-PC slot 1; with HAS_DEPC set, slot 1 is untouched.
- R9: A taken level-1 request with status_i bit 4 clear writes pc_i to save-PC slot 1. It yields exc_kind_o = 1 (user, USER_OFS vector) when status_i bit 5 is set, else 2 (kernel, KERN_OFS vector).
- R10: For a taken level-1 request, new_status_o equals status_i with bit 4 set and every other bit, including the interrupt level, kept.
- R11: With RELOC = 1, new_pc_o equals the fixed vector minus DEF_VECBASE plus vecbase_i, sampled on the accepting edge. With RELOC = 0 it equals the fixed vector.
- R12: A taken high-level request sets exc_kind_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request qualifier; updates happen only on edges where it is high |
| req_level_i | input | 4 | Pending interrupt level |
| int_set_i | input | NINT | Pending interrupt lines |
| int_en_i | input | NINT | Interrupt enable mask |
| level_mask_i | input | NLEVEL*NINT | Per-level line masks, level L at slice L-1 |
| status_i | input | ST_W | Current status word (level [3:0], exception mode [4], user mode [5]) |
| pc_i | input | XLEN | Program counter to save |
| vecbase_i | input | XLEN | Vector table base used for relocation |
| taken_o | output | 1 | One-cycle strobe: request was taken |
| new_pc_o | output | XLEN | Redirected program counter |
| new_status_o | output | ST_W | Updated status word |
| exc_kind_o | output | 2 | 0 high level, 1 user, 2 kernel, 3 double |
| cause_o | output | CAUSE_W | Exception cause register |
| save_pc_o | output | NLEVEL*XLEN | Save-PC registers, levels 1..NLEVEL |
| save_st_o | output | (NLEVEL-1)*ST_W | Save-status registers, levels 2..NLEVEL |
| depc_o | output | XLEN | Double-exception PC register |

## Verification
All save slots are visible at the ports. A write-enable decoded to the wrong level therefore shows up on the very next cycle as a changed slot that the accepted level should not have touched. A qualification error appears one edge after the request as a wrong taken_o value. The status, vector and exception-kind outputs also appear one edge later, and they either change when they should hold or hold when they should change. A stale or misrouted double-exception path shows as the PC landing in depc_o versus slot 1 on the first affected request. The reference model in the bench compares every output on every cycle, so no such error survives past the cycle that follows its cause.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int IL_W     = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_USER   = 2'd1,
    KIND_KERNEL = 2'd2,
    KIND_DOUBLE = 2'd3
  } exc_kind_e;
endpackage

// File: rtl/irqd_qualify.sv
module irqd_qualify
  import irqd_pkg::*;
#(
  parameter int NLEVEL = 6,
  parameter int NINT   = 32
) (
  input  logic                   valid_i,
  input  logic [IL_W-1:0]        level_i,
  input  logic [IL_W-1:0]        cur_il_i,
  input  logic [NINT-1:0]        set_i,
  input  logic [NINT-1:0]        en_i,
  input  logic [NLEVEL*NINT-1:0] masks_i,
  output logic                   take_o,
  output logic                   take_hi_o
);
  localparam logic [IL_W-1:0] MAX_LVL = IL_W'(NLEVEL);

  logic [NINT-1:0] mask_arr [NLEVEL+1];
  logic [NINT-1:0] sel_mask;
  logic            in_range;

  assign mask_arr[0] = '0;
  for (genvar g = 1; g <= NLEVEL; g++) begin : g_mask
    assign mask_arr[g] = masks_i[(g-1)*NINT +: NINT];
  end

  always_comb begin
    sel_mask = '0;
    for (int i = 1; i <= NLEVEL; i++) begin
      if (level_i == IL_W'(i)) sel_mask = mask_arr[i];
    end
  end

  assign in_range  = (level_i > cur_il_i) && (level_i <= MAX_LVL);
  assign take_o    = valid_i && in_range && |(sel_mask & set_i & en_i);
  assign take_hi_o = take_o && (level_i >= IL_W'(2));
endmodule

// File: rtl/irqd_vector.sv
module irqd_vector
  import irqd_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter bit          RELOC       = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'hD000_0000,
  parameter int          LVL_OFS     = 'h180,
  parameter int          LVL_STRIDE  = 'h40,
  parameter int          KERN_OFS    = 'h300,
  parameter int          USER_OFS    = 'h340,
  parameter int          DBL_OFS     = 'h3C0
) (
  input  exc_kind_e       kind_i,
  input  logic            hi_i,
  input  logic [IL_W-1:0] level_i,
  input  logic [XLEN-1:0] vecbase_i,
  output logic [XLEN-1:0] target_o
);
  localparam logic [XLEN-1:0] DEFB = XLEN'(DEF_VECBASE);

  logic [XLEN-1:0] ofs;
  logic [XLEN-1:0] fixed_addr;

  always_comb begin
    if (hi_i) begin
      ofs = XLEN'(LVL_OFS) + XLEN'(level_i - IL_W'(2)) * XLEN'(LVL_STRIDE);
    end else begin
      unique case (kind_i)
        KIND_USER:   ofs = XLEN'(USER_OFS);
        KIND_DOUBLE: ofs = XLEN'(DBL_OFS);
        default:     ofs = XLEN'(KERN_OFS);
      endcase
    end
  end

  assign fixed_addr = DEFB + ofs;

  if (RELOC) begin : g_reloc
    assign target_o = fixed_addr - DEFB + vecbase_i;
  end else begin : g_fixed
    logic unused_vb;
    assign unused_vb = ^vecbase_i;
    assign target_o  = fixed_addr;
  end
endmodule

// File: rtl/irqd_savebank.sv
module irqd_savebank
  import irqd_pkg::*;
#(
  parameter int NLEVEL   = 6,
  parameter int XLEN     = 32,
  parameter int ST_W     = 16,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_hi_i,
  input  logic                       wr_l1_i,
  input  logic                       l1_double_i,
  input  logic [IL_W-1:0]            level_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [ST_W-1:0]            status_i,
  output logic [NLEVEL*XLEN-1:0]     save_pc_o,
  output logic [(NLEVEL-1)*ST_W-1:0] save_st_o,
  output logic [XLEN-1:0]            depc_o
);
  logic l1_to_slot1;
  assign l1_to_slot1 = wr_l1_i && !(l1_double_i && HAS_DEPC);

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_pc
    logic [XLEN-1:0] pc_q;
    logic            we;
    if (g == 1) begin : g_l1
      assign we = l1_to_slot1;
    end else begin : g_hi
      assign we = wr_hi_i && (level_i == IL_W'(g));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pc_q <= '0;
      else if (we) pc_q <= pc_i;
    end
    assign save_pc_o[(g-1)*XLEN +: XLEN] = pc_q;
  end

  for (genvar g = 2; g <= NLEVEL; g++) begin : g_st
    logic [ST_W-1:0] st_q;
    logic            we;
    assign we = wr_hi_i && (level_i == IL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  st_q <= '0;
      else if (we) st_q <= status_i;
    end
    assign save_st_o[(g-2)*ST_W +: ST_W] = st_q;
  end

  if (HAS_DEPC) begin : g_depc
    logic [XLEN-1:0] depc_q;
    logic            we;
    assign we = wr_l1_i && l1_double_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  depc_q <= '0;
      else if (we) depc_q <= pc_i;
    end
    assign depc_o = depc_q;
  end else begin : g_no_depc
    assign depc_o = '0;
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int          NLEVEL      = 6,
  parameter int          NINT        = 32,
  parameter int          XLEN        = 32,
  parameter int          ST_W        = 16,
  parameter int          CAUSE_W     = 6,
  parameter int          L1_CAUSE    = 4,
  parameter bit          HAS_DEPC    = 1'b1,
  parameter bit          RELOC       = 1'b1,
  parameter logic [31:0] DEF_VECBASE = 32'hD000_0000,
  parameter int          LVL_OFS     = 'h180,
  parameter int          LVL_STRIDE  = 'h40,
  parameter int          KERN_OFS    = 'h300,
  parameter int          USER_OFS    = 'h340,
  parameter int          DBL_OFS     = 'h3C0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid_i,
  input  logic [3:0]                 req_level_i,
  input  logic [NINT-1:0]            int_set_i,
  input  logic [NINT-1:0]            int_en_i,
  input  logic [NLEVEL*NINT-1:0]     level_mask_i,
  input  logic [ST_W-1:0]            status_i,
  input  logic [XLEN-1:0]            pc_i,
  input  logic [XLEN-1:0]            vecbase_i,
  output logic                       taken_o,
  output logic [XLEN-1:0]            new_pc_o,
  output logic [ST_W-1:0]            new_status_o,
  output logic [1:0]                 exc_kind_o,
  output logic [CAUSE_W-1:0]         cause_o,
  output logic [NLEVEL*XLEN-1:0]     save_pc_o,
  output logic [(NLEVEL-1)*ST_W-1:0] save_st_o,
  output logic [XLEN-1:0]            depc_o
);
  logic            take, take_hi, take_l1, l1_double;
  exc_kind_e       kind_d, kind_q;
  logic [XLEN-1:0] target;
  logic [ST_W-1:0] status_d, status_q;
  logic [XLEN-1:0] pc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic            taken_q;

  irqd_qualify #(.NLEVEL(NLEVEL), .NINT(NINT)) u_qual (
    .valid_i   (req_valid_i),
    .level_i   (req_level_i),
    .cur_il_i  (status_i[IL_W-1:0]),
    .set_i     (int_set_i),
    .en_i      (int_en_i),
    .masks_i   (level_mask_i),
    .take_o    (take),
    .take_hi_o (take_hi)
  );

  assign take_l1   = take && !take_hi;
  assign l1_double = status_i[EXCM_BIT];

  // Next-state logic
  always_comb begin
    kind_d   = KIND_NONE;
    status_d = status_i;
    status_d[EXCM_BIT] = 1'b1;
    if (take_hi) begin
      status_d[IL_W-1:0] = req_level_i;
    end else if (l1_double) begin
      kind_d = KIND_DOUBLE;
    end else if (status_i[UM_BIT]) begin
      kind_d = KIND_USER;
    end else begin
      kind_d = KIND_KERNEL;
    end
  end

  irqd_vector #(
    .XLEN(XLEN), .RELOC(RELOC), .DEF_VECBASE(DEF_VECBASE),
    .LVL_OFS(LVL_OFS), .LVL_STRIDE(LVL_STRIDE),
    .KERN_OFS(KERN_OFS), .USER_OFS(USER_OFS), .DBL_OFS(DBL_OFS)
  ) u_vec (
    .kind_i    (kind_d),
    .hi_i      (take_hi),
    .level_i   (req_level_i),
    .vecbase_i (vecbase_i),
    .target_o  (target)
  );

  irqd_savebank #(
    .NLEVEL(NLEVEL), .XLEN(XLEN), .ST_W(ST_W), .HAS_DEPC(HAS_DEPC)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_hi_i     (take_hi),
    .wr_l1_i     (take_l1),
    .l1_double_i (l1_double),
    .level_i     (req_level_i),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .save_pc_o   (save_pc_o),
    .save_st_o   (save_st_o),
    .depc_o      (depc_o)
  );

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q  <= 1'b0;
      pc_q     <= '0;
      status_q <= '0;
      kind_q   <= KIND_NONE;
      cause_q  <= '0;
    end else begin
      taken_q <= take;
      if (take) begin
        pc_q     <= target;
        status_q <= status_d;
        kind_q   <= kind_d;
      end
      if (take_l1) cause_q <= CAUSE_W'(L1_CAUSE);
    end
  end

  assign taken_o      = taken_q;
  assign new_pc_o     = pc_q;
  assign new_status_o = status_q;
  assign exc_kind_o   = kind_q;
  assign cause_o      = cause_q;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
  import irqd_pkg::*;
#(
  parameter int NLEVEL  = 6,
  parameter int XLEN    = 32,
  parameter int ST_W    = 16,
  parameter int CAUSE_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid_i,
  input logic [3:0]                 req_level_i,
  input logic [ST_W-1:0]            status_i,
  input logic                       taken_o,
  input logic [XLEN-1:0]            new_pc_o,
  input logic [ST_W-1:0]            new_status_o,
  input logic [1:0]                 exc_kind_o,
  input logic [CAUSE_W-1:0]         cause_o,
  input logic [NLEVEL*XLEN-1:0]     save_pc_o,
  input logic [(NLEVEL-1)*ST_W-1:0] save_st_o,
  input logic [XLEN-1:0]            depc_o
);
  localparam logic [3:0] MAX_LVL = 4'(NLEVEL);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R3
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o) |-> $past(req_valid_i));

  // R2
  level_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o) |->
      ($past(req_level_i) > $past(status_i[IL_W-1:0])) && ($past(req_level_i) <= MAX_LVL));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !taken_o) |->
      ($stable(new_pc_o) && $stable(new_status_o) && $stable(exc_kind_o) &&
       $stable(cause_o) && $stable(save_pc_o) && $stable(save_st_o) && $stable(depc_o)));

  // R5
  hi_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o && exc_kind_o == KIND_NONE) |->
      (new_status_o[IL_W-1:0] == $past(req_level_i)) && new_status_o[EXCM_BIT]);

  // R10
  excm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> new_status_o[EXCM_BIT]);

  // R8
  double_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_o && exc_kind_o == KIND_DOUBLE) |-> $past(status_i[EXCM_BIT]));
endmodule

bind irq_dispatch irqd_checker #(
  .NLEVEL(NLEVEL), .XLEN(XLEN), .ST_W(ST_W), .CAUSE_W(CAUSE_W)
) u_irqd_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_level_i  (req_level_i),
  .status_i     (status_i),
  .taken_o      (taken_o),
  .new_pc_o     (new_pc_o),
  .new_status_o (new_status_o),
  .exc_kind_o   (exc_kind_o),
  .cause_o      (cause_o),
  .save_pc_o    (save_pc_o),
  .save_st_o    (save_st_o),
  .depc_o       (depc_o)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;
  localparam int NI = 32;
  localparam logic [31:0] DEFV = 32'hD000_0000;
  localparam int LOFS = 'h180, LSTR = 'h40, KOFS = 'h300, UOFS = 'h340, DOFS = 'h3C0;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid_i;
  logic [3:0] req_level_i;
  logic [NI-1:0] int_set_i, int_en_i;
  logic [NL*NI-1:0] level_mask_i;
  logic [15:0] status_i;
  logic [31:0] pc_i, vecbase_i;
  logic taken_o;
  logic [31:0] new_pc_o;
  logic [15:0] new_status_o;
  logic [1:0] exc_kind_o;
  logic [5:0] cause_o;
  logic [NL*32-1:0] save_pc_o;
  logic [(NL-1)*16-1:0] save_st_o;
  logic [31:0] depc_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch #(
    .NLEVEL(NL), .NINT(NI), .XLEN(32), .ST_W(16), .CAUSE_W(6), .L1_CAUSE(4),
    .HAS_DEPC(1'b1), .RELOC(1'b1), .DEF_VECBASE(DEFV), .LVL_OFS(LOFS),
    .LVL_STRIDE(LSTR), .KERN_OFS(KOFS), .USER_OFS(UOFS), .DBL_OFS(DOFS)
  ) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag;

  // reference state
  logic        m_taken;
  logic [31:0] m_pc, m_depc;
  logic [15:0] m_status;
  logic [1:0]  m_kind;
  logic [5:0]  m_cause;
  logic [31:0] m_epc [1:NL];
  logic [15:0] m_eps [2:NL];

  function automatic logic [31:0] mask_of(int l);
    return (l >= 1 && l <= NL) ? (32'hF << (4*l)) : 32'h0;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("taken", 32'(taken_o), 32'(m_taken));
    chk("new_pc", new_pc_o, m_pc);
    chk("new_status", 32'(new_status_o), 32'(m_status));
    chk("kind", 32'(exc_kind_o), 32'(m_kind));
    chk("cause", 32'(cause_o), 32'(m_cause));
    chk("depc", depc_o, m_depc);
    for (int l = 1; l <= NL; l++) chk($sformatf("save_pc[%0d]", l), save_pc_o[(l-1)*32 +: 32], m_epc[l]);
    for (int l = 2; l <= NL; l++) chk($sformatf("save_st[%0d]", l), 32'(save_st_o[(l-2)*16 +: 16]), 32'(m_eps[l]));
  endtask

  // Compare the previous step's results, then drive a new request and update the model.
  task automatic step(string tag, bit v, int lvl, logic [31:0] set, logic [31:0] en,
                      logic [15:0] st, logic [31:0] pc, logic [31:0] vb);
    bit take;
    int ofs;
    @(negedge clk);
    compare_all();
    cur_tag = tag;
    req_valid_i = v; req_level_i = 4'(lvl); int_set_i = set; int_en_i = en;
    status_i = st; pc_i = pc; vecbase_i = vb;
    take = v && (lvl > int'(st[3:0])) && (lvl <= NL) && ((mask_of(lvl) & set & en) != 0);
    m_taken = take;
    if (take) begin
      if (lvl >= 2) begin
        m_epc[lvl] = pc; m_eps[lvl] = st;
        m_status = (st & ~16'h000F) | 16'(lvl) | 16'h0010;
        m_kind = 2'd0;
        ofs = LOFS + (lvl - 2) * LSTR;
      end else begin
        m_cause = 6'd4;
        if (st[4]) begin
          m_depc = pc; m_kind = 2'd3; ofs = DOFS;
        end else begin
          m_epc[1] = pc; m_kind = st[5] ? 2'd1 : 2'd2; ofs = st[5] ? UOFS : KOFS;
        end
        m_status = st | 16'h0010;
      end
      m_pc = vb + 32'(ofs);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid_i = 0; req_level_i = 0; int_set_i = 0; int_en_i = 0;
    status_i = 0; pc_i = 0; vecbase_i = 0;
    for (int l = 1; l <= NL; l++) level_mask_i[(l-1)*NI +: NI] = mask_of(l);
    m_taken = 0; m_pc = 0; m_depc = 0; m_status = 0; m_kind = 0; m_cause = 0;
    for (int l = 1; l <= NL; l++) m_epc[l] = 0;
    for (int l = 2; l <= NL; l++) m_eps[l] = 0;
    cur_tag = "R1 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all();              // R1 during reset
    rst_n = 1'b1;

    step("R1 idle after reset", 0, 0, 0, 0, 16'h0, 32'h0, DEFV);
    step("R4 R5 R6 R12 level3", 1, 3, 32'h0000_F000, 32'hFFFF_FFFF, 16'h0000, 32'h1000_0010, DEFV);
    step("R2 level not above current", 1, 3, 32'h0000_F000, 32'hFFFF_FFFF, 16'h0003, 32'h1000_0020, DEFV);
    step("R2 level above NLEVEL", 1, 7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h1000_0030, DEFV);
    step("R2 enable empty", 1, 2, 32'h0000_0F00, 32'h0000_0000, 16'h0000, 32'h1000_0040, DEFV);
    step("R2 mask mismatch", 1, 2, 32'h0000_F000, 32'hFFFF_FFFF, 16'h0000, 32'h1000_0044, DEFV);
    step("R2 level zero", 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h1000_0050, DEFV);
    step("R3 valid low", 0, 4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0000, 32'h1000_0060, DEFV);
    step("R9 R7 R10 user", 1, 1, 32'h0000_00F0, 32'h0000_00F0, 16'h0020, 32'h2000_0000, DEFV);
    step("R9 kernel", 1, 1, 32'h0000_0010, 32'hFFFF_FFFF, 16'h0000, 32'h2000_0100, DEFV);
    step("R8 double", 1, 1, 32'h0000_0010, 32'hFFFF_FFFF, 16'h0030, 32'h2000_0200, DEFV);
    step("R11 relocated level6", 1, 6, 32'h0F00_0000, 32'hFFFF_FFFF, 16'h0002, 32'h3000_0000, 32'h6000_0000);
    step("R5 other bits kept", 1, 5, 32'h00F0_0000, 32'hFFFF_FFFF, 16'hA5E1, 32'h3000_0400, 32'h6000_0000);
    step("R7 high level keeps cause", 1, 2, 32'h0000_0F00, 32'hFFFF_FFFF, 16'h0001, 32'h3000_0800, DEFV);
    step("R3 back-to-back", 1, 4, 32'h0000_F000_0, 32'hFFFF_FFFF, 16'h0000, 32'h3000_0900, DEFV);
    step("R3 strobe drops", 0, 0, 0, 0, 16'h0, 32'h0, DEFV);
    step("R3 idle", 0, 0, 0, 0, 16'h0, 32'h0, DEFV);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] st;
      st = 16'($urandom);
      st[3:0] = 4'($urandom % 5);
      step("R2 R4 R8 R9 R11 random", ($urandom % 4) != 0, int'($urandom % 8),
           $urandom, $urandom, st, $urandom, {$urandom, 12'h000} & 32'hFFFF_F000);
    end
    step("R3 final idle", 0, 0, 0, 0, 16'h0, 32'h0, DEFV);
    @(negedge clk);
    compare_all();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule